// File: doc/BRIEF.md
# Staggered-Interval Radar Timing Generator

This block produces the timing strobes of a pulsed radar from one master clock: an interval-start trigger, a transmit gate, a receiver blanking window and a range-gate window. Each repetition interval takes its length from a small table of programmed values. A sequence length and a repeat count set the order in which the table is read. With a repeat count of one, every pulse moves to the next table entry, which gives a plain stagger. With a larger count, each entry is used for a group of pulses before the next entry takes over, which gives a burst schedule.

Software writes all settings through a simple write port. The settings can be rewritten while the generator is running, for example to move from a search schedule to a track schedule. New values are sampled only when an interval starts, so the interval in progress always runs on one consistent set of values. The range-gate timing is recomputed each time an interval starts, so the gate always fits inside the interval it belongs to.

Top module: `stagger_timing_gen`

## Requirements
- R1: While `rst_n` is low, and after reset until `run` is raised, all four timing outputs are low.
- R2: When `run` is sampled high at a clock edge while the generator is idle, the first interval starts on the next cycle, and that interval uses table entry 0.
- R3: Interval length equals the selected table value, except that values below 2 give a length of 2. `trig` is high for exactly the first cycle of each interval.
- R4: `tx_gate` is high during the first W cycles of an interval, where W is the pulse-width setting. W = 0 keeps it low.
- R5: `rx_blank` is high during the first max(B, W) cycles of an interval, where B is the blanking setting and W is the pulse width.
- R6: `range_gate` is high at interval offsets o that satisfy D <= o < D+G, where D is the gate delay and G is the gate width. It is always low in the last cycle of the interval.
- R7: Interval k (counting from 0 after a start) uses table entry floor(k / N) mod L. N is the repeat count, with 0 treated as 1. L is the sequence length, with 0 treated as 1 and values above 4 treated as 4.
- R8: A register write made during an interval does not change that interval. The new value applies from the next interval start onward.
- R9: If `run` is low in the last cycle of an interval, that interval completes, and afterwards all outputs stay low.
- R10: Register map on `cfg_addr`: 0 pulse width, 1 blanking length, 2 gate delay, 3 gate width, 4 sequence length (low 3 bits), 5 repeat count (low 8 bits), 8 to 11 table entries 0 to 3 (24 bits each). Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all outputs are in this domain |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Start the schedule; when low, stop at the end of the current interval |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 24 | Register write data |
| trig | output | 1 | One-cycle marker at the start of each interval |
| tx_gate | output | 1 | Transmit enable window |
| rx_blank | output | 1 | Receiver blanking window |
| range_gate | output | 1 | Range-gate window |

## Verification
The bench runs the schedule over every repeat count from 1 to 3 combined with every sequence length from 1 to 4. It also runs the out-of-range encodings 0 and 7. Each run checks all four outputs against an interval-by-interval arithmetic model on every cycle.

The table mixes unequal intervals with one entry below the minimum, so a wrong entry order or a wrong burst grouping shows up as a shifted trigger. Three window settings separate the clamping cases: blanking shorter than the pulse, a gate that extends past the end of the interval, and zero-width windows.

A rewrite in the middle of an interval shows whether the new settings are held back until the next start. Dropping `run` in the middle of each interval shows that the stop waits for the interval to finish.

// File: rtl/stg_pkg.sv
// stg_pkg: register addresses shared by the timing generator modules.
// Assumes a 4-bit write address; table entries sit at TAB_BASE + index.
package stg_pkg;
    localparam int ADDR_W   = 4;
    localparam int TAB_BASE = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_PULSE = 4'd0,
        REG_BLANK = 4'd1,
        REG_GDLY  = 4'd2,
        REG_GWID  = 4'd3,
        REG_SEQ   = 4'd4,
        REG_BURST = 4'd5
    } stg_reg_e;
endpackage

// File: rtl/stg_regfile.sv
// stg_regfile: staging registers written through the write port.
// Assumes the consumers sample these values only when an interval starts,
// so a write can never change an interval that is already running.
module stg_regfile #(
    parameter int CNT_W   = 24,
    parameter int N_ENT   = 4,
    parameter int BURST_W = 8,
    parameter int SEQ_W   = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [stg_pkg::ADDR_W-1:0]       addr,
    input  logic [CNT_W-1:0]                 wdata,
    output logic [N_ENT-1:0][CNT_W-1:0]      tab,
    output logic [CNT_W-1:0]                 pulse_len,
    output logic [CNT_W-1:0]                 blank_len,
    output logic [CNT_W-1:0]                 gate_dly,
    output logic [CNT_W-1:0]                 gate_wid,
    output logic [SEQ_W-1:0]                 seq_len,
    output logic [BURST_W-1:0]               burst_cnt
);
    import stg_pkg::*;

    // Load defaults on reset, otherwise decode one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) tab[i] <= CNT_W'(16);
            pulse_len <= CNT_W'(1);
            blank_len <= CNT_W'(2);
            gate_dly  <= CNT_W'(4);
            gate_wid  <= CNT_W'(4);
            seq_len   <= SEQ_W'(1);
            burst_cnt <= BURST_W'(1);
        end else if (we) begin
            case (addr)
                REG_PULSE: pulse_len <= wdata;
                REG_BLANK: blank_len <= wdata;
                REG_GDLY:  gate_dly  <= wdata;
                REG_GWID:  gate_wid  <= wdata;
                REG_SEQ:   seq_len   <= wdata[SEQ_W-1:0];
                REG_BURST: burst_cnt <= wdata[BURST_W-1:0];
                default: ;
            endcase
            for (int i = 0; i < N_ENT; i++)
                if (addr == ADDR_W'(TAB_BASE + i)) tab[i] <= wdata;
        end
    end
endmodule

// File: rtl/stg_sequencer.sv
// stg_sequencer: picks the table entry for each interval.
// It holds the current entry and a burst counter. When the timer starts or
// ends an interval, it advances to the next entry after burst_cnt
// intervals, wrapping at seq_len. Zero counts act as 1, and lengths
// above N_ENT act as N_ENT.
module stg_sequencer #(
    parameter int N_ENT   = 4,
    parameter int BURST_W = 8,
    parameter int SEQ_W   = 3,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               step,
    input  logic [SEQ_W-1:0]   seq_len,
    input  logic [BURST_W-1:0] burst_cnt,
    output logic [IDX_W-1:0]   nxt_idx
);
    logic [IDX_W-1:0]   idx_q;
    logic [BURST_W-1:0] bc_q, bc_d;
    logic [SEQ_W-1:0]   len_eff, idx_p1;
    logic [BURST_W-1:0] burst_eff, bc_p1;

    // Map the raw length and count to the values actually used.
    always_comb begin
        if (seq_len == '0)                 len_eff = SEQ_W'(1);
        else if (seq_len > SEQ_W'(N_ENT))  len_eff = SEQ_W'(N_ENT);
        else                               len_eff = seq_len;
        burst_eff = (burst_cnt == '0) ? BURST_W'(1) : burst_cnt;
        idx_p1    = SEQ_W'(idx_q) + SEQ_W'(1);
        bc_p1     = bc_q + BURST_W'(1);
    end

    // Select the entry and burst position for the interval about to start.
    always_comb begin
        if (start) begin
            nxt_idx = '0;
            bc_d    = '0;
        end else if (bc_p1 >= burst_eff) begin
            bc_d    = '0;
            nxt_idx = (idx_p1 >= len_eff) ? '0 : IDX_W'(idx_p1);
        end else begin
            bc_d    = bc_p1;
            nxt_idx = idx_q;
        end
    end

    // Commit the selection whenever an interval begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            bc_q  <= '0;
        end else if (start || step) begin
            idx_q <= nxt_idx;
            bc_q  <= bc_d;
        end
    end

    assert_start_entry0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (idx_q == '0) && (bc_q == '0));
    assert_entry_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (idx_q == $past(idx_q)) || (idx_q == $past(idx_q) + 1'b1) || (idx_q == '0));
endmodule

// File: rtl/stg_window.sv
// stg_window: interval counter and output window decode.
// When an interval starts, it captures the entry's length (minimum 2),
// the pulse width, the blanking length (at least the pulse width) and a
// gate window clamped so the gate closes before the last cycle. Every
// output is decoded from the offset within the interval.
module stg_window #(
    parameter int CNT_W = 24,
    parameter int N_ENT = 4,
    parameter int IDX_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run,
    input  logic [N_ENT-1:0][CNT_W-1:0] tab,
    input  logic [IDX_W-1:0]            nxt_idx,
    input  logic [CNT_W-1:0]            pulse_len,
    input  logic [CNT_W-1:0]            blank_len,
    input  logic [CNT_W-1:0]            gate_dly,
    input  logic [CNT_W-1:0]            gate_wid,
    output logic                        start,
    output logic                        step,
    output logic                        trig,
    output logic                        tx_gate,
    output logic                        rx_blank,
    output logic                        range_gate
);
    logic             active;
    logic [CNT_W-1:0] pos, cur_len, cur_pw, cur_bl, cur_gs, cur_ge;
    logic [CNT_W-1:0] sel_len, new_len, last_off, new_gs, new_ge, new_bl;
    logic [CNT_W:0]   gate_end;
    logic             at_end;

    // Work out the settings for an interval that starts this cycle.
    always_comb begin
        sel_len  = tab[nxt_idx];
        new_len  = (sel_len < CNT_W'(2)) ? CNT_W'(2) : sel_len;
        last_off = new_len - CNT_W'(1);
        gate_end = {1'b0, gate_dly} + {1'b0, gate_wid};
        new_gs   = (gate_dly > last_off) ? last_off : gate_dly;
        new_ge   = (gate_end > {1'b0, last_off}) ? last_off : gate_end[CNT_W-1:0];
        new_bl   = (blank_len > pulse_len) ? blank_len : pulse_len;
    end

    assign at_end = active && (pos == cur_len - CNT_W'(1));
    assign start  = !active && run;
    assign step   = at_end && run;

    // Advance the offset; reload at a start, and stop when run is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            pos     <= '0;
            cur_len <= CNT_W'(2);
            cur_pw  <= '0;
            cur_bl  <= '0;
            cur_gs  <= '0;
            cur_ge  <= '0;
        end else if (start || step) begin
            active  <= 1'b1;
            pos     <= '0;
            cur_len <= new_len;
            cur_pw  <= pulse_len;
            cur_bl  <= new_bl;
            cur_gs  <= new_gs;
            cur_ge  <= new_ge;
        end else if (at_end) begin
            active  <= 1'b0;
        end else if (active) begin
            pos     <= pos + CNT_W'(1);
        end
    end

    // Decode the four outputs from the interval offset.
    always_comb begin
        trig       = active && (pos == '0);
        tx_gate    = active && (pos < cur_pw);
        rx_blank   = active && (pos < cur_bl);
        range_gate = active && (pos >= cur_gs) && (pos < cur_ge);
    end

    assert_trig_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);
    assert_offset_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (pos < cur_len));
    assert_tx_inside_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_gate |-> rx_blank);
    assert_gate_closed_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        at_end |-> !range_gate);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && !run) |=> !(trig || tx_gate || rx_blank || range_gate));
endmodule

// File: rtl/stagger_timing_gen.sv
// stagger_timing_gen: top of the staggered/burst radar timing generator.
// Instantiates the staging registers, the entry sequencer and the window
// timer. Every output is registered-state decode in the clk domain.
module stagger_timing_gen #(
    parameter int CNT_W   = 24,
    parameter int N_ENT   = 4,
    parameter int BURST_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic                       cfg_we,
    input  logic [stg_pkg::ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]           cfg_wdata,
    output logic                       trig,
    output logic                       tx_gate,
    output logic                       rx_blank,
    output logic                       range_gate
);
    localparam int SEQ_W = $clog2(N_ENT + 1);
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    logic [N_ENT-1:0][CNT_W-1:0] tab;
    logic [CNT_W-1:0]            pulse_len, blank_len, gate_dly, gate_wid;
    logic [SEQ_W-1:0]            seq_len;
    logic [BURST_W-1:0]          burst_cnt;
    logic [IDX_W-1:0]            nxt_idx;
    logic                        start, step;

    stg_regfile #(.CNT_W(CNT_W), .N_ENT(N_ENT), .BURST_W(BURST_W), .SEQ_W(SEQ_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .tab(tab), .pulse_len(pulse_len), .blank_len(blank_len),
        .gate_dly(gate_dly), .gate_wid(gate_wid), .seq_len(seq_len), .burst_cnt(burst_cnt)
    );

    stg_sequencer #(.N_ENT(N_ENT), .BURST_W(BURST_W), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .step(step),
        .seq_len(seq_len), .burst_cnt(burst_cnt), .nxt_idx(nxt_idx)
    );

    stg_window #(.CNT_W(CNT_W), .N_ENT(N_ENT), .IDX_W(IDX_W)) u_win (
        .clk(clk), .rst_n(rst_n), .run(run), .tab(tab), .nxt_idx(nxt_idx),
        .pulse_len(pulse_len), .blank_len(blank_len), .gate_dly(gate_dly), .gate_wid(gate_wid),
        .start(start), .step(step), .trig(trig), .tx_gate(tx_gate),
        .rx_blank(rx_blank), .range_gate(range_gate)
    );
endmodule

// File: tb/sim_stagger_timing_gen.sv
// Bench: sweeps repeat count and sequence length, plus rewrites and stops
// in the middle of an interval. Expected outputs come from an arithmetic
// interval model built from the requirements.
module sim_stagger_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic        trig, tx_gate, rx_blank, range_gate;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    int m_tab [4];
    int m_pw, m_bl, m_gd, m_gw, m_len, m_burst;

    stagger_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .trig(trig), .tx_gate(tx_gate), .rx_blank(rx_blank),
        .range_gate(range_gate)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input logic got, input logic exp, input string tag, input int t);
        checks = checks + 1;
        if (got !== exp) begin
            failures = failures + 1;
            $display("FAIL %s t=%0d actual=%0b expected=%0b", tag, t, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 24'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic program_all();
        wr(0, m_pw); wr(1, m_bl); wr(2, m_gd); wr(3, m_gw);
        wr(4, m_len); wr(5, m_burst);
        for (int i = 0; i < 4; i++) wr(8 + i, m_tab[i]);
    endtask

    // Find interval index, offset and length for cycle t after the first trigger.
    task automatic locate(input int t, output int k, output int off, output int plen);
        int eb, el, e;
        eb = (m_burst == 0) ? 1 : m_burst;
        el = (m_len == 0) ? 1 : ((m_len > 4) ? 4 : m_len);
        k = 0; off = t;
        while (1'b1) begin
            e = (k / eb) % el;
            plen = (m_tab[e] < 2) ? 2 : m_tab[e];
            if (off < plen) break;
            off = off - plen;
            k = k + 1;
        end
    endtask

    // Start the schedule, compare each cycle, and drop run inside interval stop_k.
    task automatic run_sched(input int ncyc, input int stop_k, input string cfg);
        int k, off, plen;
        run = 1'b1;
        @(posedge clk); @(negedge clk);
        for (int t = 0; t < ncyc; t++) begin
            locate(t, k, off, plen);
            if (k > stop_k) begin
                chk(trig, 1'b0, {"R9 trig ", cfg}, t);
                chk(tx_gate, 1'b0, {"R9 tx ", cfg}, t);
                chk(rx_blank, 1'b0, {"R9 blank ", cfg}, t);
                chk(range_gate, 1'b0, {"R9 gate ", cfg}, t);
            end else begin
                chk(trig, off == 0, (t == 0) ? {"R2 trig ", cfg} : {"R3 R7 trig ", cfg}, t);
                chk(tx_gate, off < m_pw, {"R4 tx ", cfg}, t);
                chk(rx_blank, (off < m_bl) || (off < m_pw), {"R5 blank ", cfg}, t);
                chk(range_gate, (off >= m_gd) && (off < m_gd + m_gw) && (off < plen - 1),
                    {"R6 gate ", cfg}, t);
            end
            if (k == stop_k && off == 0) run = 1'b0;
            @(negedge clk);
        end
        run = 1'b0;
    endtask

    initial begin
        int sel;
        m_tab[0] = 5; m_tab[1] = 9; m_tab[2] = 1; m_tab[3] = 13;

        // R1: outputs low during and after reset while idle.
        repeat (3) @(negedge clk);
        chk(trig | tx_gate | rx_blank | range_gate, 1'b0, "R1 in reset", 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(trig | tx_gate | rx_blank | range_gate, 1'b0, "R1 idle", i);
        end

        // R7 sweep of repeat count and sequence length, three window settings.
        for (int b = 1; b <= 3; b++) begin
            for (int l = 1; l <= 4; l++) begin
                sel = (b + l) % 3;
                m_burst = b; m_len = l;
                if (sel == 0) begin m_pw = 2; m_bl = 1; m_gd = 3; m_gw = 20; end
                else if (sel == 1) begin m_pw = 3; m_bl = 6; m_gd = 1; m_gw = 2; end
                else begin m_pw = 0; m_bl = 0; m_gd = 0; m_gw = 1; end
                program_all();
                run_sched(140, 6, $sformatf("b%0d l%0d", b, l));
                repeat (20) @(negedge clk);
            end
        end

        // R7: zero and oversize encodings; R10: unmapped writes change nothing.
        m_burst = 0; m_len = 0; m_pw = 2; m_bl = 4; m_gd = 2; m_gw = 2;
        program_all();
        wr(6, 3); wr(7, 3); wr(15, 3); wr(12, 3);
        run_sched(60, 4, "R10 unmapped b0 l0");
        repeat (20) @(negedge clk);
        m_burst = 2; m_len = 7;
        program_all();
        run_sched(120, 7, "R7 b2 l7");
        repeat (20) @(negedge clk);

        // R8: rewrite during interval 0 applies only from interval 1.
        m_burst = 1; m_len = 1; m_tab[0] = 10; m_pw = 4; m_bl = 0; m_gd = 0; m_gw = 0;
        program_all();
        run = 1'b1;
        @(posedge clk); @(negedge clk);
        for (int t = 0; t < 30; t++) begin
            if (t == 0 || t == 10 || t == 16 || t == 22) chk(trig, 1'b1, "R8 trig at start", t);
            if (t == 6 || t == 9 || t == 15) chk(trig, 1'b0, "R8 no trig", t);
            if (t == 3) chk(tx_gate, 1'b1, "R8 old width kept", t);
            if (t == 11) chk(tx_gate, 1'b0, "R8 new width used", t);
            if (t == 3) begin cfg_we = 1'b1; cfg_addr = 4'd8; cfg_wdata = 24'd6; end
            else if (t == 4) begin cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 24'd1; end
            else cfg_we = 1'b0;
            @(negedge clk);
        end
        run = 1'b0;
        repeat (20) @(negedge clk);
        chk(trig | tx_gate | rx_blank | range_gate, 1'b0, "R9 stopped", 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule